// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 interrupt request lines and turns them into two processor interrupt lines: a normal line, arbitrated by a per-source 4-bit priority, and a fast line for sources that software has marked urgent. Each source has an enable bit, a class bit that selects the normal or the fast path, a software force bit and a priority. A programmable mask level keeps low-priority normal sources out of arbitration.

Software talks to the block through a 32-bit word-addressed register port. It enables or disables one source by writing its number to a dedicated register. It reads the number and priority of the winning normal source from a single vector word. Raw, forced and pending state can be read for both classes. Register state changes on the clock edge that takes a write. Interrupt outputs follow the register state and the request inputs combinationally. Read data appears one clock after the read strobe.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After synchronous reset the mask level reads 0x1F and the control word, all enable, class, force and priority bits read 0. The normal vector word reads 0xFFFF0000 and both interrupt lines are low.
- R2: Writing value n to byte address 0x08 sets the enable of source n when n < 64. Values of 64 or more change nothing. Address 0x08 reads as 0.
- R3: Writing value n to byte address 0x0C clears the enable of source n when n < 64. Values of 64 or more change nothing.
- R4: The following words are written and read back whole:
  - control at 0x00;
  - mask level in bits [4:0] of 0x04;
  - enables for sources 32..63 at 0x10 and for sources 0..31 at 0x14;
  - class bits at 0x18 (high) and 0x1C (low);
  - force bits at 0x50 (high) and 0x54 (low).
  In each high/low word, bit b stands for source b or b+32.
- R5: The priority of source n sits in bits [(n%8)*4+3:(n%8)*4] of priority group n/8. Group k is at byte address 0x20 + 4*(7-k).
- R6: A source is active when its request input or its force bit is 1.
  - Normal pending = active AND enabled AND class 0. It is read at 0x58 (high) and 0x5C (low).
  - Fast pending = active AND enabled AND class 1. It is read at 0x60 (high) and 0x64 (low).
  - The raw request inputs are read at 0x48 (high) and 0x4C (low).
- R7: The normal vector word at 0x40 holds the winning source number in bits [31:16] and its priority in bits [15:0]. With no winner it reads 0xFFFF0000.
- R8: Among eligible normal pending sources the larger priority wins. Equal priorities go to the larger source number.
- R9: When mask bit 4 is 1, every normal pending source is eligible. Otherwise a source is eligible only when its priority is strictly greater than mask bits [3:0].
- R10: The irq_norm output is high exactly when a normal winner exists. The irq_fast output is high exactly when any fast pending bit is 1.
- R11: The fast vector word at 0x44 holds the largest-numbered fast pending source in bits [31:16] and 0 in bits [15:0]. With none pending it reads 0xFFFF0000.
- R12: Read data for the address presented with bus_rd appears on bus_rdata after the next clock edge. Writes to the status words (0x40, 0x44, 0x48, 0x4C, 0x58 to 0x64) change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 7 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_src | input | 64 | Interrupt request inputs, one per source |
| irq_norm | output | 1 | Normal interrupt line |
| irq_fast | output | 1 | Fast interrupt line |

## Verification
Assertions check several things on every cycle:
- enable set and clear by number, and the reset values;
- that the normal winner is pending and no eligible source outranks it;
- that either interrupt line is high only when a matching enabled source exists.

The bench covers what needs a software view. It sweeps a single active source across all 64 numbers and checks the priority-word address reversal and the nibble placement. It sweeps the mask level across every threshold against an arithmetic model of the winner. It also covers ties, class moves, force bits and writes to status words that must be ignored.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NSRC     = 64;
    localparam int WORD_W   = 32;
    localparam int PRIO_W   = 4;
    localparam int MASK_W   = 5;
    localparam int ADDR_W   = 7;
    localparam int IDX_W    = ADDR_W - 2;
    localparam int ID_W     = $clog2(NSRC);
    localparam int PER_WORD = WORD_W / PRIO_W;
    localparam int NGROUP   = NSRC / PER_WORD;
    localparam int HALF     = NSRC / 2;

    // word indices (byte address / 4)
    localparam logic [IDX_W-1:0] W_CTRL  = 5'd0;
    localparam logic [IDX_W-1:0] W_MASK  = 5'd1;
    localparam logic [IDX_W-1:0] W_ENSET = 5'd2;
    localparam logic [IDX_W-1:0] W_ENCLR = 5'd3;
    localparam logic [IDX_W-1:0] W_ENH   = 5'd4;
    localparam logic [IDX_W-1:0] W_ENL   = 5'd5;
    localparam logic [IDX_W-1:0] W_TYH   = 5'd6;
    localparam logic [IDX_W-1:0] W_TYL   = 5'd7;
    localparam int               W_PBASE = 8;
    localparam logic [IDX_W-1:0] W_NVEC  = 5'd16;
    localparam logic [IDX_W-1:0] W_FVEC  = 5'd17;
    localparam logic [IDX_W-1:0] W_SRCH  = 5'd18;
    localparam logic [IDX_W-1:0] W_SRCL  = 5'd19;
    localparam logic [IDX_W-1:0] W_FRH   = 5'd20;
    localparam logic [IDX_W-1:0] W_FRL   = 5'd21;
    localparam logic [IDX_W-1:0] W_NPH   = 5'd22;
    localparam logic [IDX_W-1:0] W_NPL   = 5'd23;
    localparam logic [IDX_W-1:0] W_FPH   = 5'd24;
    localparam logic [IDX_W-1:0] W_FPL   = 5'd25;

    localparam logic [WORD_W-1:0] NO_VEC = 32'hFFFF_0000;

    typedef struct packed {
        logic              found;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } win_t;

    // word index of priority group k (highest group at lowest address)
    function automatic logic [IDX_W-1:0] group_idx(input int k);
        return IDX_W'(W_PBASE + NGROUP - 1 - k);
    endfunction

    function automatic logic [WORD_W-1:0] vec_word(input win_t w);
        return w.found ? {16'(w.id), 16'(w.prio)} : NO_VEC;
    endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int PW = PRIO_W,
    parameter int MW = MASK_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr,
    input  logic [IDX_W-1:0]        widx,
    input  logic [WORD_W-1:0]       wdata,
    output logic [WORD_W-1:0]       ctrl,
    output logic [MW-1:0]           mask,
    output logic [N-1:0]            en,
    output logic [N-1:0]            typ,
    output logic [N-1:0]            frc,
    output logic [N-1:0][PW-1:0]    prio
);
    localparam int H = N / 2;

    logic num_ok;
    assign num_ok = (wdata[WORD_W-1:ID_W] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            mask <= '1;
            en   <= '0;
            typ  <= '0;
            frc  <= '0;
            prio <= '0;
        end else if (wr) begin
            case (widx)
                W_CTRL:  ctrl <= wdata;
                W_MASK:  mask <= wdata[MW-1:0];
                W_ENSET: if (num_ok) en[wdata[ID_W-1:0]] <= 1'b1;
                W_ENCLR: if (num_ok) en[wdata[ID_W-1:0]] <= 1'b0;
                W_ENH:   en[N-1:H]   <= wdata[H-1:0];
                W_ENL:   en[H-1:0]   <= wdata[H-1:0];
                W_TYH:   typ[N-1:H]  <= wdata[H-1:0];
                W_TYL:   typ[H-1:0]  <= wdata[H-1:0];
                W_FRH:   frc[N-1:H]  <= wdata[H-1:0];
                W_FRL:   frc[H-1:0]  <= wdata[H-1:0];
                default: ;
            endcase
            for (int k = 0; k < NGROUP; k++) begin
                if (widx == group_idx(k)) begin
                    for (int j = 0; j < PER_WORD; j++)
                        prio[k*PER_WORD+j] <= wdata[j*PW +: PW];
                end
            end
        end
    end

    // checker state for number-indexed writes
    logic            chk_set, chk_clr;
    logic [ID_W-1:0] chk_id;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_set <= 1'b0;
            chk_clr <= 1'b0;
            chk_id  <= '0;
        end else begin
            chk_set <= wr && widx == W_ENSET && num_ok;
            chk_clr <= wr && widx == W_ENCLR && num_ok;
            chk_id  <= wdata[ID_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            // R2
            enset_chk: assert (!chk_set || en[chk_id]);
            // R3
            enclr_chk: assert (!chk_clr || !en[chk_id]);
        end
    end

    // R1
    reset_val_chk: assert property (@(posedge clk)
        rst |=> (mask == '1 && en == '0 && typ == '0 && prio == '0));
endmodule

// File: rtl/pic_arb.sv
module pic_arb
    import pic_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int PW = PRIO_W,
    parameter int MW = MASK_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         npend,
    input  logic [N-1:0][PW-1:0] prio,
    input  logic [MW-1:0]        mask,
    output win_t                 win
);
    logic [N-1:0] elig;

    always_comb begin
        for (int i = 0; i < N; i++)
            elig[i] = npend[i] && (mask[MW-1] || (MW'(prio[i]) > mask));
    end

    // ascending scan, ">=" hands ties to the larger number
    always_comb begin
        win = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!win.found || prio[i] >= win.prio)) begin
                win.found = 1'b1;
                win.id    = ID_W'(i);
                win.prio  = prio[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && win.found) begin
            // R7
            win_pend_chk: assert (npend[win.id]);
            for (int i = 0; i < N; i++) begin
                if (elig[i]) begin
                    // R8
                    win_max_chk: assert (prio[i] < win.prio ||
                        (prio[i] == win.prio && ID_W'(i) <= win.id));
                end
            end
        end
    end
endmodule

// File: rtl/pic_fpick.sv
module pic_fpick
    import pic_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]    fpend,
    output logic            found,
    output logic [ID_W-1:0] id
);
    always_comb begin
        found = 1'b0;
        id    = '0;
        for (int i = 0; i < N; i++) begin
            if (fpend[i]) begin
                found = 1'b1;
                id    = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   irq_src,
    output logic              irq_norm,
    output logic              irq_fast
);
    logic [IDX_W-1:0]              widx;
    logic [WORD_W-1:0]             ctrl;
    logic [MASK_W-1:0]             mask;
    logic [NSRC-1:0]               en, typ, frc, active, npend, fpend;
    logic [NSRC-1:0][PRIO_W-1:0]   prio;
    win_t                          nwin;
    logic                          f_found;
    logic [ID_W-1:0]               f_id;
    logic [WORD_W-1:0]             rd_val;

    assign widx = bus_addr[ADDR_W-1:2];

    pic_regs #(.N(NSRC), .PW(PRIO_W), .MW(MASK_W)) i_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .widx(widx), .wdata(bus_wdata),
        .ctrl(ctrl), .mask(mask), .en(en), .typ(typ), .frc(frc), .prio(prio)
    );

    assign active = irq_src | frc;
    assign npend  = active & en & ~typ;
    assign fpend  = active & en & typ;

    pic_arb #(.N(NSRC), .PW(PRIO_W), .MW(MASK_W)) i_arb (
        .clk(clk), .rst(rst), .npend(npend), .prio(prio), .mask(mask), .win(nwin)
    );

    pic_fpick #(.N(NSRC)) i_fpick (
        .fpend(fpend), .found(f_found), .id(f_id)
    );

    assign irq_norm = nwin.found;
    assign irq_fast = |fpend;

    always_comb begin
        rd_val = '0;
        case (widx)
            W_CTRL: rd_val = ctrl;
            W_MASK: rd_val = WORD_W'(mask);
            W_ENH:  rd_val = en[NSRC-1:HALF];
            W_ENL:  rd_val = en[HALF-1:0];
            W_TYH:  rd_val = typ[NSRC-1:HALF];
            W_TYL:  rd_val = typ[HALF-1:0];
            W_NVEC: rd_val = vec_word(nwin);
            W_FVEC: rd_val = f_found ? {16'(f_id), 16'h0} : NO_VEC;
            W_SRCH: rd_val = irq_src[NSRC-1:HALF];
            W_SRCL: rd_val = irq_src[HALF-1:0];
            W_FRH:  rd_val = frc[NSRC-1:HALF];
            W_FRL:  rd_val = frc[HALF-1:0];
            W_NPH:  rd_val = npend[NSRC-1:HALF];
            W_NPL:  rd_val = npend[HALF-1:0];
            W_FPH:  rd_val = fpend[NSRC-1:HALF];
            W_FPL:  rd_val = fpend[HALF-1:0];
            default: ;
        endcase
        for (int k = 0; k < NGROUP; k++) begin
            if (widx == group_idx(k)) begin
                for (int j = 0; j < PER_WORD; j++)
                    rd_val[j*PRIO_W +: PRIO_W] = prio[k*PER_WORD+j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    // R10
    fast_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_fast |-> (|(en & typ & (irq_src | frc))));
    // R10
    norm_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_norm |-> (|(en & ~typ)));
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_src = '0;
    logic        irq_norm, irq_fast;

    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    // model state
    logic [63:0] en_m = '0, typ_m = '0, frc_m = '0;
    int          prio_m [64];
    int          mask_m = 31;

    always #10 clk = ~clk;

    vec_irq_ctrl i_vec_irq_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 7'(addr); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 7'(addr);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input int addr, input logic [31:0] exp);
        logic [31:0] d;
        rd(addr, d);
        check(req, d, exp);
    endtask

    function automatic logic [31:0] nvec_exp();
        bit found = 0;
        int bi = 0, bp = 0;
        for (int i = 0; i < 64; i++) begin
            if ((irq_src[i] | frc_m[i]) & en_m[i] & ~typ_m[i])
                if (mask_m >= 16 || prio_m[i] > mask_m)
                    if (!found || prio_m[i] >= bp) begin
                        found = 1; bi = i; bp = prio_m[i];
                    end
        end
        return found ? {16'(bi), 16'(bp)} : 32'hFFFF0000;
    endfunction

    function automatic logic [31:0] group_word(input int k);
        logic [31:0] w = '0;
        for (int j = 0; j < 8; j++) w[j*4 +: 4] = 4'(prio_m[k*8+j]);
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 64; i++) prio_m[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 mask", 'h04, 32'h1F);
        rd_chk("R1 ctrl", 'h00, 32'h0);
        rd_chk("R1 enl", 'h14, 32'h0);
        rd_chk("R1 prio", 'h3C, 32'h0);
        rd_chk("R1 nvec", 'h40, 32'hFFFF0000);
        check("R1 lines", {30'h0, irq_norm, irq_fast}, 32'h0);

        // R4 control word
        wr('h00, 32'hA5C3_0F01);
        rd_chk("R4 ctrl", 'h00, 32'hA5C3_0F01);

        // R2 enable by number, full sweep
        for (int n = 0; n < 64; n++) begin
            wr('h08, 32'(n));
            en_m[n] = 1'b1;
            rd_chk("R2 enl", 'h14, en_m[31:0]);
            rd_chk("R2 enh", 'h10, en_m[63:32]);
        end
        rd_chk("R2 reads zero", 'h08, 32'h0);

        // R3 out of range clear ignored, then clear even sources
        wr('h0C, 32'h45);
        rd_chk("R3 out of range", 'h14, en_m[31:0]);
        for (int n = 0; n < 64; n += 2) begin
            wr('h0C, 32'(n));
            en_m[n] = 1'b0;
        end
        rd_chk("R3 clear low", 'h14, en_m[31:0]);
        rd_chk("R3 clear high", 'h10, en_m[63:32]);
        wr('h14, 32'hFFFF_FFFF); wr('h10, 32'hFFFF_FFFF); en_m = '1;
        rd_chk("R4 enh", 'h10, 32'hFFFF_FFFF);

        // R5 priority layout
        for (int n = 0; n < 64; n++) prio_m[n] = (n * 5 + 3) % 16;
        for (int k = 0; k < 8; k++) wr('h20 + 4 * (7 - k), group_word(k));
        for (int k = 0; k < 8; k++) rd_chk("R5 readback", 'h20 + 4 * (7 - k), group_word(k));

        // R5 R7 R10 single active source sweep
        for (int n = 0; n < 64; n++) begin
            @(negedge clk);
            irq_src = 64'h1 << n;
            rd_chk("R5 R7 single", 'h40, {16'(n), 16'(prio_m[n])});
            check("R10 norm line", {31'h0, irq_norm}, 32'h1);
        end

        // R6 raw and pending views
        @(negedge clk);
        irq_src = 64'hF0F0_1234_8000_0001;
        rd_chk("R6 src low", 'h4C, 32'h8000_0001);
        rd_chk("R6 npend high", 'h58, 32'hF0F0_1234);

        // R8 R9 mask sweep with all sources active
        @(negedge clk);
        irq_src = '1;
        for (int m = 0; m < 17; m++) begin
            wr('h04, 32'(m)); mask_m = m;
            rd_chk("R9 mask sweep", 'h40, nvec_exp());
            check("R9 norm line", {31'h0, irq_norm}, {31'h0, nvec_exp() != 32'hFFFF0000});
        end
        wr('h04, 32'h1F); mask_m = 31;
        rd_chk("R8 all active", 'h40, nvec_exp());

        // R8 ties resolve to larger number
        for (int n = 0; n < 64; n++) prio_m[n] = 7;
        for (int k = 0; k < 8; k++) wr('h20 + 4 * k, 32'h7777_7777);
        rd_chk("R8 tie", 'h40, {16'd63, 16'd7});
        wr('h0C, 32'd63); en_m[63] = 1'b0;
        rd_chk("R3 R8 tie after clear", 'h40, {16'd62, 16'd7});

        // R6 R10 R11 class bits move high half to fast path
        wr('h18, 32'hFFFF_FFFF); typ_m[63:32] = '1;
        rd_chk("R11 fvec", 'h44, {16'd62, 16'd0});
        rd_chk("R8 normal after class", 'h40, {16'd31, 16'd7});
        rd_chk("R6 fpend high", 'h60, 32'h7FFF_FFFF);
        rd_chk("R6 npend high zero", 'h58, 32'h0);
        check("R10 fast line", {31'h0, irq_fast}, 32'h1);

        // R6 R4 force bits
        @(negedge clk);
        irq_src = '0;
        rd_chk("R11 none", 'h44, 32'hFFFF0000);
        check("R10 lines idle", {30'h0, irq_norm, irq_fast}, 32'h0);
        wr('h54, 32'h0000_0400); frc_m[10] = 1'b1;
        rd_chk("R4 force readback", 'h54, 32'h0000_0400);
        rd_chk("R6 force pending", 'h40, {16'd10, 16'd7});

        // R12 writes to status words ignored
        wr('h40, 32'h1234_5678);
        rd_chk("R12 nvec", 'h40, {16'd10, 16'd7});
        wr('h5C, 32'h0);
        rd_chk("R12 npend", 'h5C, 32'h0000_0400);
        wr('h4C, 32'hFFFF_FFFF);
        rd_chk("R12 src", 'h4C, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule